// File: doc/BRIEF.md
# CAN Bit Timing Unit with Configuration Handshake

This block turns a programmable timing word into the quantum-level schedule of one CAN bit. A prescaler divides the system clock into time quanta; a segment state machine walks each bit through a one-quantum sync segment, a first timing segment (propagation plus phase 1) and a second phase segment. At the end of the first segment it strobes the sampled receive value out, and at every bit start it pulses a transmit-point strobe. Falling edges on the receive line, seen between consecutive quantum samples, lengthen or shorten the current bit within the resync jump width. When enabled, and only with a slow enough quantum, the sampled value is a majority vote over three quanta.

The timing word can only change while the engine is parked in configuration mode. Software sets a request bit in the control word; the engine finishes the bit in progress, parks, and raises `cfg_en`. Timing writes are then accepted. Clearing the request restarts bit timing from a fresh sync segment on the next cycle.

States: `ST_CFG` (parked, timing writable), `ST_SYNC` (sync quantum), `ST_SEG1` (first timing segment), `ST_SEG2` (second phase segment). Transitions: `ST_CFG`→`ST_SYNC` when the request is low; `ST_SYNC`→`ST_SEG1` on a quantum tick; `ST_SEG1`→`ST_SEG2` on the tick that ends the (possibly lengthened) segment, which fires the sample strobe; `ST_SEG2`→`ST_SYNC` at the bit end with the request low, or `ST_SEG2`→`ST_CFG` at the bit end with the request high.

Top module: `can_bit_timer`

## Requirements
- R1: Timing word layout: bits [2:0] = phase-2 length minus one (T2 = 1..8), bits [6:3] = segment-1 length minus one (T1 = 1..16), bit 7 = triple-sample enable, bits [9:8] = jump width minus one (SJW = 1..4), bits [23:16] = prescaler minus one; one quantum Q lasts (bits[23:16]+1) clock cycles.
- R2: A bit lasts (1 + T1 + T2) quanta; `sample_stb` follows `tx_stb` by (1+T1)·Q cycles and the next `tx_stb` follows `sample_stb` by T2·Q cycles; the two strobes are never high together.
- R3: Writing the control word (`wr_sel`=0) with bit 12 set makes `cfg_en` rise exactly T2·Q cycles after the last `sample_stb`, in place of that bit's `tx_stb`.
- R4: Writing the control word with bit 12 clear while `cfg_en` is high makes `cfg_en` fall one cycle after the write edge, with `tx_stb` high in that same cycle, starting a new bit.
- R5: A timing-word write (`wr_sel`=1) while `cfg_en` is low is ignored: the bit timing observed at the strobes is unchanged.
- R6: While `cfg_en` is high neither strobe pulses.
- R7: With single sampling, `sample_val` equals `rx_bit` at the quantum that ends segment 1.
- R8: With bit 7 set and prescaler field ≥ 4 (prescaler > 4), `sample_val` is the majority of `rx_bit` over the last three quanta ending at the sample point; with a smaller prescaler the bit is sampled once.
- R9: A falling edge seen at segment-1 quantum index p (0-based) lengthens segment 1 by min(p+1, SJW) quanta.
- R10: A falling edge seen at phase-2 quantum index p with r = T2−p quanta remaining ends the bit at that quantum if r ≤ SJW; otherwise phase 2 is shortened by SJW quanta.
- R11: A falling edge seen in the sync quantum does not change the bit timing.
- R12: After reset `cfg_en`, `sample_stb` and `tx_stb` are low and the timing word is zero (Q=1, T1=1, T2=1, SJW=1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = control word, 1 = timing word |
| wr_data | input | WORD_W | Write data |
| rx_bit | input | 1 | Received bus level (1 = recessive) |
| sample_stb | output | 1 | One-cycle pulse at the sample point |
| sample_val | output | 1 | Sampled bit value, valid from `sample_stb` |
| tx_stb | output | 1 | One-cycle pulse at each bit start |
| cfg_en | output | 1 | High while parked in configuration mode |

## Verification
A corrupted segment counter or extension register shows up as a wrong spacing between consecutive strobes within the very bit it occurs in, so every strobe interval is compared against a count derived from the timing word. A stuck or late handshake state shows as `cfg_en` rising at the wrong bit boundary, a missing `tx_stb` on release, or strobes while parked, each visible within one bit time. A wrong sample history appears only in the value strobed at the sample point, so glitch patterns are placed on the quanta just before it.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
    localparam int T2_LSB     = 0;
    localparam int T2_W       = 3;
    localparam int T1_LSB     = 3;
    localparam int T1_W       = 4;
    localparam int TRIPLE_POS = 7;
    localparam int SJW_LSB    = 8;
    localparam int SJW_W      = 2;
    localparam int BRP_LSB    = 16;
    localparam int BRP_W      = 8;
    localparam int TWORD_W    = BRP_LSB + BRP_W;
    localparam int TRIPLE_MIN = 4;   // prescaler field value at which voting is allowed
    localparam int QCNT_W     = 6;   // holds T1 + SJW extension

    typedef struct packed {
        logic [BRP_W-1:0] brp;
        logic [SJW_W-1:0] sjw;
        logic             triple;
        logic [T1_W-1:0]  tseg1;
        logic [T2_W-1:0]  tseg2;
    } timing_t;

    typedef enum logic [1:0] {ST_CFG, ST_SYNC, ST_SEG1, ST_SEG2} seg_state_e;

    function automatic timing_t unpack_timing(input logic [TWORD_W-1:0] w);
        timing_t t;
        t.brp    = w[BRP_LSB +: BRP_W];
        t.sjw    = w[SJW_LSB +: SJW_W];
        t.triple = w[TRIPLE_POS];
        t.tseg1  = w[T1_LSB +: T1_W];
        t.tseg2  = w[T2_LSB +: T2_W];
        return t;
    endfunction
endpackage

// File: rtl/cbt_cfg_regs.sv
module cbt_cfg_regs
    import cbt_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int REQ_BIT = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wr_sel,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic                cfg_en,
    output logic                req,
    output logic [TWORD_W-1:0]  tword
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req   <= 1'b0;
            tword <= '0;
        end else if (wr_en) begin
            if (!wr_sel)
                req <= wr_data[REQ_BIT];
            else if (cfg_en)
                tword <= wr_data[TWORD_W-1:0];
        end
    end
endmodule

// File: rtl/cbt_prescaler.sv
module cbt_prescaler #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             tick
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || cnt_q == limit)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick = run && (cnt_q == limit);
endmodule

// File: rtl/cbt_sampler.sv
module cbt_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rx,
    input  logic vote_on,
    output logic fall,
    output logic bit_val
);
    logic [1:0] hist_q;   // [0] = level at the previous tick, [1] = the one before
    logic       maj;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hist_q <= 2'b11;
        else if (tick)
            hist_q <= {hist_q[0], rx};
    end

    always_comb begin
        maj     = (hist_q[1] & hist_q[0]) | (hist_q[1] & rx) | (hist_q[0] & rx);
        fall    = tick && hist_q[0] && !rx;
        bit_val = vote_on ? maj : rx;
    end
endmodule

// File: rtl/cbt_seg_fsm.sv
module cbt_seg_fsm
    import cbt_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tick,
    input  logic    fall,
    input  logic    bit_val,
    input  logic    req,
    input  timing_t timing,
    output logic    run,
    output logic    sample_stb,
    output logic    sample_val,
    output logic    tx_stb,
    output logic    cfg_en
);
    seg_state_e        state_q, state_d;
    logic [QCNT_W-1:0] qc_q, qc_d, ext_q, ext_d, short_q, short_d;
    logic              resync_q, resync_d;
    logic [QCNT_W-1:0] t1_len, t2_len, sjw_len, err1, rem2, ext_eff, short_eff;
    logic              edge_ok, seg1_last, seg2_last, at_sample;

    // segment lengths and resynchronisation arithmetic
    always_comb begin
        t1_len    = QCNT_W'(timing.tseg1) + QCNT_W'(1);
        t2_len    = QCNT_W'(timing.tseg2) + QCNT_W'(1);
        sjw_len   = QCNT_W'(timing.sjw) + QCNT_W'(1);
        edge_ok   = fall && !resync_q;
        err1      = qc_q + QCNT_W'(1);
        rem2      = t2_len - qc_q;
        ext_eff   = ext_q;
        if (state_q == ST_SEG1 && edge_ok)
            ext_eff = (err1 < sjw_len) ? err1 : sjw_len;
        short_eff = short_q;
        if (state_q == ST_SEG2 && edge_ok && rem2 > sjw_len)
            short_eff = sjw_len;
        seg1_last = (qc_q == t1_len - QCNT_W'(1) + ext_eff);
        seg2_last = (edge_ok && rem2 <= sjw_len) || (qc_q + short_eff == t2_len - QCNT_W'(1));
        at_sample = (state_q == ST_SEG1) && tick && seg1_last;
    end

    // next-state logic
    always_comb begin
        state_d  = state_q;
        qc_d     = qc_q;
        ext_d    = ext_q;
        short_d  = short_q;
        resync_d = resync_q;
        unique case (state_q)
            ST_CFG: begin
                if (!req) begin
                    state_d  = ST_SYNC;
                    qc_d     = '0;
                    ext_d    = '0;
                    short_d  = '0;
                    resync_d = 1'b0;
                end
            end
            ST_SYNC: begin
                if (tick) begin
                    state_d = ST_SEG1;
                    qc_d    = '0;
                end
            end
            ST_SEG1: begin
                if (tick) begin
                    if (seg1_last) begin
                        state_d = ST_SEG2;
                        qc_d    = '0;
                    end else begin
                        qc_d = qc_q + QCNT_W'(1);
                    end
                    ext_d    = ext_eff;
                    resync_d = resync_q | edge_ok;
                end
            end
            ST_SEG2: begin
                if (tick) begin
                    if (seg2_last) begin
                        state_d  = req ? ST_CFG : ST_SYNC;
                        qc_d     = '0;
                        ext_d    = '0;
                        short_d  = '0;
                        resync_d = 1'b0;
                    end else begin
                        qc_d     = qc_q + QCNT_W'(1);
                        short_d  = short_eff;
                        resync_d = resync_q | edge_ok;
                    end
                end
            end
            default: state_d = ST_CFG;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_SYNC;
            qc_q     <= '0;
            ext_q    <= '0;
            short_q  <= '0;
            resync_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            qc_q     <= qc_d;
            ext_q    <= ext_d;
            short_q  <= short_d;
            resync_q <= resync_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample_stb <= 1'b0;
            sample_val <= 1'b1;
            tx_stb     <= 1'b0;
            cfg_en     <= 1'b0;
        end else begin
            sample_stb <= at_sample;
            if (at_sample)
                sample_val <= bit_val;
            tx_stb     <= (state_d == ST_SYNC) && (state_q != ST_SYNC);
            cfg_en     <= (state_d == ST_CFG);
        end
    end

    assign run = (state_q != ST_CFG);
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
    import cbt_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int REQ_BIT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rx_bit,
    output logic              sample_stb,
    output logic              sample_val,
    output logic              tx_stb,
    output logic              cfg_en
);
    logic               req_w;
    logic [TWORD_W-1:0] tword_w;
    timing_t            timing_w;
    logic               run_w, tick_w, fall_w, bit_w, vote_w;

    cbt_cfg_regs #(.WORD_W(WORD_W), .REQ_BIT(REQ_BIT)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .cfg_en(cfg_en), .req(req_w), .tword(tword_w)
    );

    assign timing_w = unpack_timing(tword_w);
    assign vote_w   = timing_w.triple && (timing_w.brp >= BRP_W'(TRIPLE_MIN));

    cbt_prescaler #(.CNT_W(BRP_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(run_w), .limit(timing_w.brp), .tick(tick_w)
    );

    cbt_sampler u_samp (
        .clk(clk), .rst_n(rst_n), .tick(tick_w), .rx(rx_bit),
        .vote_on(vote_w), .fall(fall_w), .bit_val(bit_w)
    );

    cbt_seg_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick_w), .fall(fall_w), .bit_val(bit_w),
        .req(req_w), .timing(timing_w), .run(run_w), .sample_stb(sample_stb),
        .sample_val(sample_val), .tx_stb(tx_stb), .cfg_en(cfg_en)
    );
endmodule

// File: rtl/cbt_checks.sv
module cbt_checks
    import cbt_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_en,
    input logic               sample_stb,
    input logic               tx_stb,
    input logic               req,
    input logic [TWORD_W-1:0] tword
);
    a_r6_quiet_in_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |-> (!sample_stb && !tx_stb));

    a_r2_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_stb && tx_stb));

    a_r4_release_starts_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_en) |-> tx_stb);

    a_r3_park_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_en) |-> $past(req));

    a_r5_word_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> $stable(tword));
endmodule

bind can_bit_timer cbt_checks chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .sample_stb(sample_stb),
    .tx_stb(tx_stb), .req(req_w), .tword(tword_w)
);

// File: tb/can_bit_timer_tb_top.sv
`timescale 1ns/100ps
module can_bit_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rx_bit = 1'b1;
    logic        sample_stb, sample_val, tx_stb, cfg_en;

    int nchk = 0;
    int nerr = 0;
    int cyc = 0;
    int last_cyc = 0;
    bit done = 0;

    typedef struct {
        bit    is_tx;
        int    delta;
        int    val;     // -1: value not compared
        string tag;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;   // 200 MHz

    can_bit_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rx_bit(rx_bit), .sample_stb(sample_stb), .sample_val(sample_val),
        .tx_stb(tx_stb), .cfg_en(cfg_en)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && (sample_stb || tx_stb)) begin
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.is_tx == tx_stb, {e.tag, " strobe kind"}, int'(tx_stb), int'(e.is_tx));
                chk((cyc - last_cyc) == e.delta, {e.tag, " strobe spacing"}, cyc - last_cyc, e.delta);
                if (e.val >= 0)
                    chk(int'(sample_val) == e.val, {e.tag, " sample value"}, int'(sample_val), e.val);
            end
            last_cyc = cyc;
        end
    end

    function automatic logic [31:0] mk(input int brp, input int sjw, input int tri_s,
                                       input int t1, input int t2);
        return (32'(brp) << 16) | (32'(sjw) << 8) | (32'(tri_s) << 7) | (32'(t1) << 3) | 32'(t2);
    endfunction

    task automatic push(input bit is_tx, input int delta, input int val, input string tag);
        exp_t e;
        e.is_tx = is_tx; e.delta = delta; e.val = val; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        wr_sel = sel; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_tx();
        do @(negedge clk); while (!tx_stb);
        #1;
    endtask

    task automatic wait_sample();
        do @(negedge clk); while (!sample_stb);
        #1;
    endtask

    task automatic drain(input string tag);
        int k = 0;
        while (exp_q.size() > 0 && k < 3000) begin
            @(negedge clk);
            k++;
        end
        chk(exp_q.size() == 0, {tag, " expected strobes arrived"}, exp_q.size(), 0);
        exp_q.delete();
        #1;
    endtask

    // park, load a timing word, release; R3 / R4 handshake checked every time
    task automatic reconfig(input logic [31:0] word);
        int k = 0;
        wr(1'b0, 32'h0000_1000);
        while (!cfg_en && k < 5000) begin
            @(negedge clk);
            k++;
        end
        chk(cfg_en == 1'b1, "R3 park acknowledged", int'(cfg_en), 1);
        wr(1'b1, word);
        wr(1'b0, 32'h0);
        chk(cfg_en == 1'b1, "R4 still parked at release edge", int'(cfg_en), 1);
        @(negedge clk);
        chk(cfg_en == 1'b0, "R4 cfg_en falls", int'(cfg_en), 0);
        chk(tx_stb == 1'b1, "R4 new bit starts", int'(tx_stb), 1);
        #1;
    endtask

    task automatic test_plain(input int q, input int t1, input int t2, input string tag);
        wait_tx();
        push(1'b0, (1 + t1) * q, -1, tag);
        push(1'b1, t2 * q, -1, tag);
        drain(tag);
    endtask

    // low for two quanta before the sample point, high at it
    task automatic test_vote(input int q, input int t1, input int t2, input int expv, input string tag);
        rx_bit = 1'b1;
        wait_tx();
        wait_tx();
        rx_bit = 1'b0;                         // falls in the sync quantum (R11)
        push(1'b0, (1 + t1) * q, expv, tag);
        push(1'b1, t2 * q, -1, "R11");
        repeat (t1 * q) @(negedge clk);
        rx_bit = 1'b1;
        drain(tag);
    endtask

    task automatic test_late(input int q, input int t1, input int t2, input int sjw, input int pos);
        int ext;
        ext = (pos + 1 < sjw) ? pos + 1 : sjw;
        wait_tx();
        rx_bit = 1'b1;
        push(1'b0, (1 + t1 + ext) * q, 0, "R9");   // value low at sample: R7
        push(1'b1, t2 * q, -1, "R9");
        repeat ((1 + pos) * q) @(negedge clk);
        rx_bit = 1'b0;
        drain("R9");
    endtask

    task automatic test_early(input int q, input int t1, input int t2, input int sjw, input int pos);
        int r, seg;
        r   = t2 - pos;
        seg = (r <= sjw) ? pos + 1 : t2 - sjw;
        wait_tx();
        rx_bit = 1'b1;
        push(1'b0, (1 + t1) * q, 1, "R7");
        push(1'b1, seg * q, -1, "R10");
        wait_sample();
        repeat (pos * q) @(negedge clk);
        rx_bit = 1'b0;
        drain("R10");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R12 reset state
        chk(cfg_en == 1'b0, "R12 cfg_en in reset", int'(cfg_en), 0);
        chk(sample_stb == 1'b0, "R12 sample_stb in reset", int'(sample_stb), 0);
        chk(tx_stb == 1'b0, "R12 tx_stb in reset", int'(tx_stb), 0);
        rst_n = 1'b1;
        test_plain(1, 1, 1, "R12");

        // R5: timing write while running is dropped
        wr(1'b1, mk(9, 3, 1, 7, 7));
        chk(cfg_en == 1'b0, "R5 not parked", int'(cfg_en), 0);
        test_plain(1, 1, 1, "R5");

        // R2: Q=3, T1=3, T2=2
        reconfig(mk(2, 0, 0, 2, 1));
        test_plain(3, 3, 2, "R2");

        // R3: park exactly T2*Q after the sample strobe
        begin
            int cnt = 1;
            bit quiet = 1;
            wait_sample();
            wr(1'b0, 32'h0000_1000);
            while (!cfg_en && cnt < 1000) begin
                @(negedge clk);
                cnt++;
            end
            chk(cnt == 6, "R3 park delay", cnt, 6);
            chk(tx_stb == 1'b0, "R3 no tx strobe at park", int'(tx_stb), 0);
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (sample_stb || tx_stb || !cfg_en) quiet = 0;
            end
            chk(quiet, "R6 silent while parked", int'(quiet), 1);
            wr(1'b1, mk(20, 0, 0, 4, 2));
            wr(1'b0, 32'h0);
            @(negedge clk);
            chk(cfg_en == 1'b0, "R4 cfg_en falls", int'(cfg_en), 0);
            chk(tx_stb == 1'b1, "R4 new bit starts", int'(tx_stb), 1);
            #1;
        end
        // R1: Q=21, T1=5, T2=3
        test_plain(21, 5, 3, "R1");

        // R8: voting with prescaler 5, single sample with prescaler 4
        reconfig(mk(4, 0, 1, 2, 1));
        test_vote(5, 3, 2, 0, "R8");
        reconfig(mk(3, 0, 1, 2, 1));
        test_vote(4, 3, 2, 1, "R8");

        // R9: late edge at segment-1 index 1, SJW 1 and 2
        reconfig(mk(1, 0, 0, 2, 1));
        test_late(2, 3, 2, 1, 1);
        reconfig(mk(1, 1, 0, 2, 1));
        test_late(2, 3, 2, 2, 1);

        // R10: early edge at phase-2 index 1, SJW 1 and 4
        reconfig(mk(1, 0, 0, 2, 3));
        test_early(2, 3, 4, 1, 1);
        reconfig(mk(1, 3, 0, 2, 3));
        test_early(2, 3, 4, 4, 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        #750000;
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule